// File: doc/BRIEF.md
# Serial Fuse Word Programming Sequencer

This block is the timed engine behind a one-time-programmable fuse array. Software stages up to four data words, one per staging slot, and writing slot 0 launches a burn of one 32-bit fuse word. The address's low bits pick which staged slot carries the data. Because slot 0 is the trigger, it has to be written last. The burn starts by reading the target word bit by bit. The new data is then masked so that fuses already blown are never strobed again. The masked word sits in a shift register that moves right with zero fill, one bit per step, starting at the least significant bit. A program strobe is applied only for bits that are 1.

Phase lengths come from a packed timing word: a program strobe count, a read strobe count and a relax count. A separate count sets a quiet interval after the last step. Busy stays high through that interval. When it ends, a one-cycle done pulse is given and the block returns to idle. The fuse array is reached through a one-bit port: an index, a read strobe, a program strobe and the read bit.

Top module: `fuse_burn_seq`

## Requirements
- R1: Four staging slots (select 0..3) are written only while busy and done are both low. A write to slot 0 in that state launches a burn of word `word_addr`, using the slot numbered by `word_addr[1:0]`. When that slot is 0, the data is the value being written. Staging writes made while busy or done is high have no effect. All slots reset to zero.
- R2: The pre-read visits bits 0 to 31 in order. Each bit gets a read strobe of max(RD,1) cycles followed by a relax phase of RLX+1 cycles.
- R3: Only bits that are 1 in the data and 0 in the pre-read word are strobed. Afterwards the fuse word equals its old value OR the data.
- R4: Program strobes go out in rising bit order. Each lasts max(PG,1) cycles, with `fuse_idx` = {word address, bit number}. Strobes occur only while busy.
- R5: Every programming step, strobed or not, ends with a relax phase of RLX+1 cycles, and there are always 32 steps. Busy therefore lasts 32*(max(RD,1)+RLX+1) + N*max(PG,1) + 32*(RLX+1) + HOLD+1 cycles, where N is the number of strobed bits.
- R6: The timing word fields are PG in bits [11:0], RLX in bits [15:12] and RD in bits [21:16]. Bits [31:22] have no effect.
- R7: After the last step, a quiet interval of `hold_cycles`+1 cycles follows with busy still high and no strobes.
- R8: Done is a one-cycle pulse in the first cycle with busy low after a burn. Busy never falls without it.
- R9: After reset, busy, done, `fuse_rd` and `fuse_prog` are low.
- R10: `fuse_rd` and `fuse_prog` are never high together, and `fuse_idx` is stable across a program strobe.
- R11: Address, timing word and hold count are captured at launch. Changing them during a burn has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_we | input | 1 | Staging slot write strobe |
| stage_sel | input | 2 | Staging slot number; 0 launches |
| stage_wdata | input | 32 | Staging write data |
| word_addr | input | 4 | Fuse word address; low 2 bits pick the data slot |
| timing_word | input | 32 | Packed phase counts (PG, RLX, RD) |
| hold_cycles | input | 16 | Post-write quiet interval minus one |
| busy | output | 1 | Burn in progress |
| done | output | 1 | One-cycle end-of-burn pulse |
| fuse_idx | output | 9 | Fuse bit index {word, bit} |
| fuse_rd | output | 1 | Fuse read strobe |
| fuse_prog | output | 1 | Fuse program strobe |
| fuse_rdata | input | 1 | Fuse bit read back |

## Verification
The properties assume that `fuse_rdata` reflects the indexed fuse bit while `fuse_rd` is high. They also assume that staging inputs change only between clock edges. The fuse model in the bench returns the bit addressed by `fuse_idx` combinationally, and it blows a bit only during a program strobe. All stimulus is driven on the falling edge. Random timing words, hold counts and old fuse contents are drawn with reserved bits set freely. Some burns are disturbed mid-flight by changing the address, timing and staging inputs; the properties must still hold, and the captured values must still govern.

// File: rtl/fuse_seq_pkg.sv
// Shared definitions for the fuse programming sequencer.
// Assumes a packed timing word with fixed field positions.
package fuse_seq_pkg;
    localparam int PG_W   = 12;
    localparam int PG_LSB = 0;
    localparam int RLX_W  = 4;
    localparam int RLX_LSB = 12;
    localparam int RD_W   = 6;
    localparam int RD_LSB = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STB,
        ST_RD_RLX,
        ST_PG_STB,
        ST_PG_RLX,
        ST_HOLD,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/fuse_timing_decode.sv
// Splits the packed timing word into phase lengths minus one.
// Assumes a zero strobe field means a one-cycle strobe; reserved bits unused.
module fuse_timing_decode
    import fuse_seq_pkg::*;
(
    input  logic [31:0]      timing_word,
    output logic [PG_W-1:0]  prog_m1,
    output logic [RD_W-1:0]  read_m1,
    output logic [RLX_W-1:0] relax_m1
);
    logic [PG_W-1:0]  pg_f;
    logic [RD_W-1:0]  rd_f;

    // Extract fields and convert to terminal counts
    always_comb begin
        pg_f     = timing_word[PG_LSB +: PG_W];
        rd_f     = timing_word[RD_LSB +: RD_W];
        relax_m1 = timing_word[RLX_LSB +: RLX_W];
        prog_m1  = (pg_f == '0) ? '0 : pg_f - PG_W'(1);
        read_m1  = (rd_f == '0) ? '0 : rd_f - RD_W'(1);
    end
endmodule

// File: rtl/fuse_stage_bank.sv
// Holds the staged data words; writing slot 0 while accepting launches a burn.
// Assumes accept is high only when the controller is idle.
module fuse_stage_bank #(
    parameter int DATA_W  = 32,
    parameter int STAGE_N = 4,
    localparam int SEL_W  = $clog2(STAGE_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              accept,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              launch
);
    logic [DATA_W-1:0] slot_q [STAGE_N];

    assign launch = we && accept && (sel == '0);

    // Store accepted staging writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGE_N; i++) slot_q[i] <= '0;
        end else if (we && accept) begin
            slot_q[sel] <= wdata;
        end
    end

    // Burn data: slot 0 bypasses the value written in the launch cycle
    always_comb begin
        if (launch && rd_sel == '0) rd_data = wdata;
        else                        rd_data = slot_q[rd_sel];
    end
endmodule

// File: rtl/fuse_burn_ctrl.sv
// Phase sequencer: serial pre-read, masked LSB-first burn, quiet hold, done.
// Assumes fuse_rdata is valid on the last cycle of each read strobe.
module fuse_burn_ctrl
    import fuse_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int HOLD_W = 16,
    localparam int BIT_W = $clog2(DATA_W),
    localparam int CNT_W = (HOLD_W > PG_W) ? HOLD_W : PG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic [DATA_W-1:0]       word_in,
    input  logic [PG_W-1:0]         prog_m1,
    input  logic [RD_W-1:0]         read_m1,
    input  logic [RLX_W-1:0]        relax_m1,
    input  logic [HOLD_W-1:0]       hold_in,
    input  logic                    fuse_rdata,
    output logic                    idle,
    output logic                    busy,
    output logic                    done,
    output logic [ADDR_W+BIT_W-1:0] fuse_idx,
    output logic                    fuse_rd,
    output logic                    fuse_prog
);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

    seq_state_t         state;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bitn;
    logic [ADDR_W-1:0]  waddr;
    logic [DATA_W-1:0]  shreg;
    logic [DATA_W-1:0]  rdword;
    logic [PG_W-1:0]    prog_q;
    logic [RD_W-1:0]    read_q;
    logic [RLX_W-1:0]   relax_q;
    logic [HOLD_W-1:0]  hold_q;
    logic [DATA_W-1:0]  masked;

    // Data with already-blown fuses removed
    assign masked = shreg & ~rdword;

    // Phase sequencing, down-counter, shift register and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            waddr   <= '0;
            shreg   <= '0;
            rdword  <= '0;
            prog_q  <= '0;
            read_q  <= '0;
            relax_q <= '0;
            hold_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (launch) begin
                    state   <= ST_RD_STB;
                    cnt     <= CNT_W'(read_m1);
                    bitn    <= '0;
                    waddr   <= addr_in;
                    shreg   <= word_in;
                    rdword  <= '0;
                    prog_q  <= prog_m1;
                    read_q  <= read_m1;
                    relax_q <= relax_m1;
                    hold_q  <= hold_in;
                end
                ST_RD_STB: if (cnt == '0) begin
                    rdword[bitn] <= fuse_rdata;
                    state        <= ST_RD_RLX;
                    cnt          <= CNT_W'(relax_q);
                end else cnt <= cnt - CNT_W'(1);
                ST_RD_RLX: if (cnt == '0) begin
                    if (bitn == LAST) begin
                        bitn  <= '0;
                        shreg <= masked;
                        state <= masked[0] ? ST_PG_STB : ST_PG_RLX;
                        cnt   <= masked[0] ? CNT_W'(prog_q) : CNT_W'(relax_q);
                    end else begin
                        bitn  <= bitn + BIT_W'(1);
                        state <= ST_RD_STB;
                        cnt   <= CNT_W'(read_q);
                    end
                end else cnt <= cnt - CNT_W'(1);
                ST_PG_STB: if (cnt == '0) begin
                    state <= ST_PG_RLX;
                    cnt   <= CNT_W'(relax_q);
                end else cnt <= cnt - CNT_W'(1);
                ST_PG_RLX: if (cnt == '0) begin
                    shreg <= shreg >> 1;
                    if (bitn == LAST) begin
                        state <= ST_HOLD;
                        cnt   <= CNT_W'(hold_q);
                    end else begin
                        bitn  <= bitn + BIT_W'(1);
                        state <= shreg[1] ? ST_PG_STB : ST_PG_RLX;
                        cnt   <= shreg[1] ? CNT_W'(prog_q) : CNT_W'(relax_q);
                    end
                end else cnt <= cnt - CNT_W'(1);
                ST_HOLD: if (cnt == '0) state <= ST_DONE;
                         else cnt <= cnt - CNT_W'(1);
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle      = (state == ST_IDLE);
    assign done      = (state == ST_DONE);
    assign busy      = !idle && !done;
    assign fuse_rd   = (state == ST_RD_STB);
    assign fuse_prog = (state == ST_PG_STB);
    assign fuse_idx  = {waddr, bitn};
endmodule

// File: rtl/fuse_burn_seq.sv
// Top: staging slots, timing decode and burn sequencer for one fuse word.
// Assumes inputs synchronous to clk; word_addr is at least SEL_W bits wide.
module fuse_burn_seq #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int HOLD_W  = 16,
    parameter int STAGE_N = 4,
    localparam int SEL_W  = $clog2(STAGE_N),
    localparam int IDX_W  = ADDR_W + $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_we,
    input  logic [SEL_W-1:0]  stage_sel,
    input  logic [DATA_W-1:0] stage_wdata,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [31:0]       timing_word,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  fuse_idx,
    output logic              fuse_rd,
    output logic              fuse_prog,
    input  logic              fuse_rdata
);
    import fuse_seq_pkg::*;

    logic              idle;
    logic              launch;
    logic [DATA_W-1:0] burn_word;
    logic [PG_W-1:0]   prog_m1;
    logic [RD_W-1:0]   read_m1;
    logic [RLX_W-1:0]  relax_m1;

    fuse_stage_bank #(.DATA_W(DATA_W), .STAGE_N(STAGE_N)) u_stage (
        .clk(clk), .rst_n(rst_n), .we(stage_we), .sel(stage_sel),
        .wdata(stage_wdata), .accept(idle), .rd_sel(word_addr[SEL_W-1:0]),
        .rd_data(burn_word), .launch(launch)
    );

    fuse_timing_decode u_tdec (
        .timing_word(timing_word), .prog_m1(prog_m1),
        .read_m1(read_m1), .relax_m1(relax_m1)
    );

    fuse_burn_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HOLD_W(HOLD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .launch(launch), .addr_in(word_addr),
        .word_in(burn_word), .prog_m1(prog_m1), .read_m1(read_m1),
        .relax_m1(relax_m1), .hold_in(hold_cycles), .fuse_rdata(fuse_rdata),
        .idle(idle), .busy(busy), .done(done), .fuse_idx(fuse_idx),
        .fuse_rd(fuse_rd), .fuse_prog(fuse_prog)
    );
endmodule

// File: rtl/fuse_burn_seq_chk.sv
// Protocol properties of the fuse burn sequencer, bound to its top module.
// Assumes staging inputs only change between clock edges.
module fuse_burn_seq_chk #(
    parameter int SEL_W = 2,
    parameter int IDX_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stage_we,
    input logic [SEL_W-1:0] stage_sel,
    input logic             busy,
    input logic             done,
    input logic [IDX_W-1:0] fuse_idx,
    input logic             fuse_rd,
    input logic             fuse_prog
);
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_rd && fuse_prog));

    p_idx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_prog && $past(fuse_prog)) |-> $stable(fuse_idx));

    p_strobe_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_rd || fuse_prog) |-> busy);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_we && stage_sel == '0 && !busy && !done) |=> busy);
endmodule

bind fuse_burn_seq fuse_burn_seq_chk #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_sel(stage_sel),
    .busy(busy), .done(done), .fuse_idx(fuse_idx),
    .fuse_rd(fuse_rd), .fuse_prog(fuse_prog)
);

// File: tb/sim_fuse_burn_seq.sv
// Self-checking bench: random and directed burns against a fuse array model.
module sim_fuse_burn_seq;
    localparam int AW = 4;
    localparam int NW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stage_we = 1'b0;
    logic [1:0]  stage_sel = '0;
    logic [31:0] stage_wdata = '0;
    logic [3:0]  word_addr = '0;
    logic [31:0] timing_word = '0;
    logic [15:0] hold_cycles = '0;
    logic        busy, done, fuse_rd, fuse_prog;
    logic [8:0]  fuse_idx;
    logic        fuse_rdata;

    logic [31:0] fmem [NW];
    logic [31:0] sm [4];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    int busy_cnt, done_cnt, done_busy_err, addr_err, order_err, last_bit;
    bit have_last, prev_prog;
    int rd_cyc [32];
    int pg_cyc [32];
    logic [3:0] cur_addr;

    always #4 clk = ~clk;

    fuse_burn_seq u0 (
        .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_sel(stage_sel),
        .stage_wdata(stage_wdata), .word_addr(word_addr),
        .timing_word(timing_word), .hold_cycles(hold_cycles), .busy(busy),
        .done(done), .fuse_idx(fuse_idx), .fuse_rd(fuse_rd),
        .fuse_prog(fuse_prog), .fuse_rdata(fuse_rdata)
    );

    assign fuse_rdata = fmem[fuse_idx[8:5]][fuse_idx[4:0]];

    // Fuse model: a strobed bit blows
    always @(posedge clk) if (fuse_prog) fmem[fuse_idx[8:5]][fuse_idx[4:0]] <= 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Global watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Port monitor, sampled away from the active edge
    always @(negedge clk) if (mon_en) begin
        if (busy) busy_cnt++;
        if (done) begin
            done_cnt++;
            if (busy) done_busy_err++;
        end
        if (fuse_rd) begin
            rd_cyc[fuse_idx[4:0]]++;
            if (fuse_idx[8:5] != cur_addr) addr_err++;
        end
        if (fuse_prog) begin
            pg_cyc[fuse_idx[4:0]]++;
            if (fuse_idx[8:5] != cur_addr) addr_err++;
            if (!prev_prog) begin
                if (have_last && int'(fuse_idx[4:0]) <= last_bit) order_err++;
                last_bit = int'(fuse_idx[4:0]);
                have_last = 1'b1;
            end
        end
        prev_prog = fuse_prog;
    end

    task automatic stage_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        if (!busy && !done) sm[sel] = d;
        stage_we = 1'b1; stage_sel = sel; stage_wdata = d;
        @(negedge clk);
        stage_we = 1'b0;
    endtask

    task automatic run_op(input logic [3:0] a, input logic [31:0] d0,
                          input logic [31:0] tw, input logic [15:0] hc,
                          input logic [31:0] oldv, input bit disturb);
        logic [31:0] data, burn, finalv;
        int p, r, rl, nb, exp_busy, rd_bad, pg_bad, wait_n;
        @(negedge clk);
        fmem[a] = oldv;
        data = (a[1:0] == 2'd0) ? d0 : sm[a[1:0]];
        burn = data & ~oldv;
        nb = $countones(burn);
        p  = (tw[11:0] == 0) ? 1 : int'(tw[11:0]);
        r  = (tw[21:16] == 0) ? 1 : int'(tw[21:16]);
        rl = int'(tw[15:12]);
        exp_busy = 32*(r + rl + 1) + nb*p + 32*(rl + 1) + int'(hc) + 1;
        busy_cnt = 0; done_cnt = 0; done_busy_err = 0; addr_err = 0;
        order_err = 0; have_last = 1'b0; prev_prog = 1'b0; cur_addr = a;
        for (int i = 0; i < 32; i++) begin rd_cyc[i] = 0; pg_cyc[i] = 0; end
        sm[0] = d0;
        stage_we = 1'b1; stage_sel = 2'd0; stage_wdata = d0;
        word_addr = a; timing_word = tw; hold_cycles = hc;
        mon_en = 1'b1;
        @(negedge clk);
        stage_we = 1'b0;
        if (disturb) begin
            // R11 and R1: inputs change and staging writes land during the burn
            repeat (5) @(negedge clk);
            word_addr = a ^ 4'hF;
            timing_word = $urandom;
            hold_cycles = 16'($urandom_range(0, 300));
            stage_write(2'd2, $urandom);
            stage_write(2'd0, $urandom);
        end
        wait_n = 0;
        while (done_cnt == 0 && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        repeat (2) @(negedge clk);
        mon_en = 1'b0;
        finalv = fmem[a];
        rd_bad = 0; pg_bad = 0;
        for (int i = 0; i < 32; i++) begin
            if (rd_cyc[i] != r) rd_bad++;
            if (pg_cyc[i] != (burn[i] ? p : 0)) pg_bad++;
        end
        chk(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
        chk(done_busy_err == 0, "R8", "done with busy", done_busy_err, 0);
        chk(finalv == (oldv | data), "R3", "final fuse word", finalv, oldv | data);
        chk(rd_bad == 0, "R2", "bits with wrong read strobe length", rd_bad, 0);
        chk(pg_bad == 0, "R4", "bits with wrong program strobe length", pg_bad, 0);
        chk(order_err == 0 && addr_err == 0, "R4", "strobe order or index errors",
            order_err + addr_err, 0);
        chk(busy_cnt == exp_busy, "R5", "busy cycles (R6 fields, R7 hold, R11)",
            busy_cnt, exp_busy);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NW; i++) fmem[i] = '0;
        for (int i = 0; i < 4; i++) sm[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(!busy && !done && !fuse_rd && !fuse_prog, "R9", "outputs after reset",
            {busy, done, fuse_rd, fuse_prog}, 0);
        // R1: slot 3 never written -> reset value zero, nothing strobed
        run_op(4'd3, 32'hDEAD_BEEF, 32'h0001_1003, 16'd4, 32'h0000_00F0, 1'b0);
        // R3/R5: all ones into blank word, zero strobe field means one cycle
        run_op(4'd4, 32'hFFFF_FFFF, 32'h0000_0000, 16'd0, 32'h0, 1'b0);
        // R3: fully blown word, nothing burns
        run_op(4'd8, 32'h1234_5678, 32'h0002_2005, 16'd3, 32'hFFFF_FFFF, 1'b0);
        // R5: zero data, relax-only steps
        run_op(4'd0, 32'h0, 32'h0003_1002, 16'd7, 32'h0F0F_0000, 1'b0);
        // R6: reserved bits set
        run_op(4'd12, 32'hA5A5_0F0F, 32'hFFC1_2004, 16'd2, 32'h0000_FF00, 1'b0);
        // R1: staged slots used by address low bits
        stage_write(2'd1, 32'h8000_0001);
        stage_write(2'd2, 32'h00FF_0000);
        run_op(4'd5, 32'h0, 32'h0001_0003, 16'd1, 32'h0, 1'b0);
        // R11/R1: disturbed burn; the busy-time write to slot 2 must be ignored
        run_op(4'd2, 32'h0, 32'h0002_1006, 16'd9, 32'h0000_0100, 1'b1);
        run_op(4'd6, 32'h0, 32'h0001_1002, 16'd5, 32'h0, 1'b0);
        // Random burns, some disturbed
        for (int k = 0; k < 30; k++) begin
            logic [31:0] tw;
            if (k % 4 == 1) stage_write(2'($urandom_range(1, 3)), $urandom);
            tw = {10'($urandom), 6'($urandom_range(0, 4)), 4'($urandom_range(0, 3)),
                  12'($urandom_range(0, 9))};
            run_op(4'($urandom), $urandom, tw, 16'($urandom_range(0, 40)),
                   $urandom & $urandom, (k % 5 == 2));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule